// File: doc/BRIEF.md
# RAM Address Register Unit

This block holds the 12-bit data-memory pointer of a small 4-bit processor. The pointer is three nibbles: low, middle and high. A decoded micro-operation code selects what happens in each cycle. The pointer can be loaded whole or in its low nibble. It can count its low nibble up or down, and it can swap the low nibble with the accumulator or the middle nibble with the X register. On memory operations it presents the address, strobes and write data to an external nibble-wide RAM. It then passes the returned nibble back toward the accumulator.

Two details make it more than a plain register. First, each memory operation flips bits 6:4 of the pointer with the complement of three immediate bits from the instruction. This happens after the access, so a loop can walk between register files. Second, a mask can be armed ahead of time. It clears chosen address bits for the single memory operation that follows and then drops by itself. The full pointer is always driven on a separate bus so that peripherals can decode it during I/O cycles.

Top module: `ramaddr_unit`

## Requirements
- R1: A synchronous active-high reset sets the pointer, the mask, `skip`, `acc_wr` and `x_wr` to zero.
- R2: `addr_bus` always shows the pointer. Code 8 loads all 12 bits from `ld_val`. Code 9 loads only bits 3:0 from `ld_val[3:0]`, and the upper bits keep their value.
- R3: `ram_addr` equals the pointer ANDed with the complement of the mask. Code 10 arms the mask with `ld_val`.
- R4: The mask returns to zero after the clock edge that ends a memory operation (codes 1, 2, 3). Any other code leaves it unchanged.
- R5: Code 1 (memory load) raises `ram_rd` in its own cycle. In the next cycle it raises `acc_wr` with `acc_wdata` equal to the `mem_rdata` sampled during the access. After the access, pointer bits 6:4 are XORed with `~op_imm`.
- R6: Code 2 (memory swap) raises both `ram_rd` and `ram_wr`, and `ram_wdata` equals `acc_in`. It returns the old memory nibble through `acc_wr`/`acc_wdata` one cycle later and applies the same bits 6:4 XOR.
- R7: Code 3 (swap and count down) does everything code 2 does. It also lowers bits 3:0 by one modulo 16 and pulses `skip` when the result is 15.
- R8: Code 4 raises bits 3:0 by one modulo 16, with bits 11:4 unchanged, and pulses `skip` when the result is 0.
- R9: Code 5 lowers bits 3:0 by one modulo 16, with bits 11:4 unchanged, and pulses `skip` when the result is 15.
- R10: Code 6 puts `acc_in` into bits 3:0 and returns the old bits 3:0 through `acc_wr`/`acc_wdata` one cycle later. Bits 11:4 are unchanged.
- R11: Code 7 puts `x_in` into bits 7:4 and returns the old bits 7:4 through `x_wr`/`x_wdata` one cycle later.
- R12: `skip` is high for exactly the one cycle after a wrapping code 3, 4 or 5 and is low at all other times. Codes 0 and 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Decoded micro-operation (codes in R2 to R12) |
| op_imm | input | 3 | Low instruction bits used by the bits 6:4 XOR |
| acc_in | input | 4 | Current accumulator value |
| x_in | input | 4 | Current X register value |
| ld_val | input | 12 | Load value for pointer or mask |
| mem_rdata | input | 4 | Nibble returned by the RAM during an access |
| addr_bus | output | 12 | Pointer, always driven |
| ram_addr | output | 12 | Masked RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 4 | RAM write data |
| acc_wr | output | 1 | Accumulator update request |
| acc_wdata | output | 4 | New accumulator value |
| x_wr | output | 1 | X register update request |
| x_wdata | output | 4 | New X register value |
| skip | output | 1 | Skip pulse on counter wrap |

## Verification
The RAM strobes, `ram_wdata` and `ram_addr` belong to the cycle in which the operation code is presented. The bench checks them a short delay after it drives the inputs and before the clock edge. The pointer on `addr_bus`, `skip`, and the accumulator and X write-backs become valid one edge later. The bench therefore compares them at the following falling edge against a reference model that was advanced by that operation. The model runs a directed sequence aimed at wraps, mask persistence and one-shot clearing, followed by a random stream, and it is compared on every cycle.

// File: rtl/ramaddr_pkg.sv
package ramaddr_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE          = 4'd0,
    OP_MEM_LD        = 4'd1,
    OP_MEM_SWAP      = 4'd2,
    OP_MEM_SWAP_DEC  = 4'd3,
    OP_LO_INC        = 4'd4,
    OP_LO_DEC        = 4'd5,
    OP_SWAP_ACC_LO   = 4'd6,
    OP_SWAP_X_MID    = 4'd7,
    OP_LOAD_ALL      = 4'd8,
    OP_LOAD_LO       = 4'd9,
    OP_ARM_MASK      = 4'd10
  } uop_e;
endpackage

// File: rtl/ramaddr_lo_step.sv
// Low-nibble counter step: one adder, direction chosen per cycle.
module ramaddr_lo_step #(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] lo_cur,
  input  logic             down,
  output logic [NIB_W-1:0] lo_next,
  output logic             wrap
);
  localparam logic [NIB_W-1:0] ONE  = NIB_W'(1);
  localparam logic [NIB_W-1:0] ZERO = '0;
  localparam logic [NIB_W-1:0] TOP  = '1;

  always_comb begin
    lo_next = down ? (lo_cur - ONE) : (lo_cur + ONE);
    wrap    = down ? (lo_next == TOP) : (lo_next == ZERO);
  end
endmodule

// File: rtl/ramaddr_mid_flip.sv
// Flips the low XOR_W bits of the middle nibble with the inverted immediate.
module ramaddr_mid_flip #(
  parameter int NIB_W = 4,
  parameter int XOR_W = 3
) (
  input  logic [NIB_W-1:0] mid_cur,
  input  logic [XOR_W-1:0] imm,
  output logic [NIB_W-1:0] mid_next
);
  logic [NIB_W-1:0] flip_vec;

  generate
    if (NIB_W > XOR_W) begin : g_pad
      assign flip_vec = {{(NIB_W-XOR_W){1'b0}}, ~imm};
    end else begin : g_full
      assign flip_vec = ~imm[NIB_W-1:0];
    end
  endgenerate

  assign mid_next = mid_cur ^ flip_vec;
endmodule

// File: rtl/ramaddr_mask.sv
// One-shot address mask: armed by a load, dropped after one memory access.
module ramaddr_mask #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_val,
  input  logic              consume,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (arm) begin
      mask_q <= arm_val;
    end else if (consume) begin
      mask_q <= '0;
    end
  end

  assign eff_addr = ptr & ~mask_q;
endmodule

// File: rtl/ramaddr_unit.sv
module ramaddr_unit
  import ramaddr_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 12,
  parameter int XOR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_code,
  input  logic [XOR_W-1:0]  op_imm,
  input  logic [NIB_W-1:0]  acc_in,
  input  logic [NIB_W-1:0]  x_in,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [NIB_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0] addr_bus,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [NIB_W-1:0]  ram_wdata,
  output logic              acc_wr,
  output logic [NIB_W-1:0]  acc_wdata,
  output logic              x_wr,
  output logic [NIB_W-1:0]  x_wdata,
  output logic              skip
);
  localparam int MID_LO = NIB_W;

  uop_e op;
  assign op = uop_e'(op_code);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [NIB_W-1:0]  lo_cur, mid_cur, lo_step, mid_flip;
  logic              step_down, step_wrap;
  logic              is_mem, is_swap, is_count;

  assign lo_cur  = ptr_q[NIB_W-1:0];
  assign mid_cur = ptr_q[MID_LO +: NIB_W];

  always_comb begin
    is_mem    = (op == OP_MEM_LD) || (op == OP_MEM_SWAP) || (op == OP_MEM_SWAP_DEC);
    is_swap   = (op == OP_MEM_SWAP) || (op == OP_MEM_SWAP_DEC);
    step_down = (op == OP_LO_DEC) || (op == OP_MEM_SWAP_DEC);
    is_count  = step_down || (op == OP_LO_INC);
  end

  ramaddr_lo_step #(.NIB_W(NIB_W)) u_step (
    .lo_cur  (lo_cur),
    .down    (step_down),
    .lo_next (lo_step),
    .wrap    (step_wrap)
  );

  ramaddr_mid_flip #(.NIB_W(NIB_W), .XOR_W(XOR_W)) u_flip (
    .mid_cur  (mid_cur),
    .imm      (op_imm),
    .mid_next (mid_flip)
  );

  ramaddr_mask #(.ADDR_W(ADDR_W)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .arm      (op == OP_ARM_MASK),
    .arm_val  (ld_val),
    .consume  (is_mem),
    .ptr      (ptr_q),
    .eff_addr (ram_addr)
  );

  always_comb begin
    ptr_d = ptr_q;
    case (op)
      OP_MEM_LD, OP_MEM_SWAP: ptr_d[MID_LO +: NIB_W] = mid_flip;
      OP_MEM_SWAP_DEC: begin
        ptr_d[MID_LO +: NIB_W] = mid_flip;
        ptr_d[NIB_W-1:0]       = lo_step;
      end
      OP_LO_INC, OP_LO_DEC:   ptr_d[NIB_W-1:0] = lo_step;
      OP_SWAP_ACC_LO:         ptr_d[NIB_W-1:0] = acc_in;
      OP_SWAP_X_MID:          ptr_d[MID_LO +: NIB_W] = x_in;
      OP_LOAD_ALL:            ptr_d = ld_val;
      OP_LOAD_LO:             ptr_d[NIB_W-1:0] = ld_val[NIB_W-1:0];
      default:                ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      skip      <= 1'b0;
      acc_wr    <= 1'b0;
      acc_wdata <= '0;
      x_wr      <= 1'b0;
      x_wdata   <= '0;
    end else begin
      ptr_q     <= ptr_d;
      skip      <= is_count && step_wrap;
      acc_wr    <= is_mem || (op == OP_SWAP_ACC_LO);
      acc_wdata <= (op == OP_SWAP_ACC_LO) ? lo_cur : mem_rdata;
      x_wr      <= (op == OP_SWAP_X_MID);
      x_wdata   <= mid_cur;
    end
  end

  assign addr_bus  = ptr_q;
  assign ram_rd    = is_mem;
  assign ram_wr    = is_swap;
  assign ram_wdata = acc_in;
endmodule

// File: rtl/ramaddr_unit_chk.sv
module ramaddr_unit_chk
  import ramaddr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_code,
  input logic [ADDR_W-1:0] addr_bus,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_rd,
  input logic              ram_wr,
  input logic              acc_wr,
  input logic              x_wr,
  input logic              skip
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_bus == '0 && !skip && !acc_wr && !x_wr));

  p_mask_oneshot_r4: assert property (@(posedge clk) disable iff (rst)
    (ram_rd || ram_wr) |=> (ram_addr == addr_bus));

  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LO_INC && addr_bus[3:0] == 4'hF) |=> (skip && addr_bus[3:0] == 4'h0));

  p_dec_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_LO_DEC && addr_bus[3:0] == 4'h0) |=> (skip && addr_bus[3:0] == 4'hF));

  p_acc_lo_upper_r10: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_SWAP_ACC_LO) |=> (addr_bus[ADDR_W-1:4] == $past(addr_bus[ADDR_W-1:4])));

  p_skip_cause_r12: assert property (@(posedge clk) disable iff (rst)
    (op_code != OP_LO_INC && op_code != OP_LO_DEC && op_code != OP_MEM_SWAP_DEC) |=> !skip);

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_IDLE || op_code > OP_ARM_MASK) |=> $stable(addr_bus));

  p_swap_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    ram_wr |-> ram_rd);
endmodule

bind ramaddr_unit ramaddr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_code  (op_code),
  .addr_bus (addr_bus),
  .ram_addr (ram_addr),
  .ram_rd   (ram_rd),
  .ram_wr   (ram_wr),
  .acc_wr   (acc_wr),
  .x_wr     (x_wr),
  .skip     (skip)
);

// File: tb/ramaddr_unit_tb.sv
module ramaddr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic [2:0]  op_imm = '0;
  logic [3:0]  acc_in = '0, x_in = '0, mem_rdata = '0;
  logic [11:0] ld_val = '0;
  logic [11:0] addr_bus, ram_addr;
  logic        ram_rd, ram_wr, acc_wr, x_wr, skip;
  logic [3:0]  ram_wdata, acc_wdata, x_wdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [11:0] m_ptr = '0, m_mask = '0;
  logic        e_skip = 0, e_accwr = 0, e_xwr = 0;
  logic [3:0]  e_acc = '0, e_x = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramaddr_unit u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .op_imm(op_imm), .acc_in(acc_in),
    .x_in(x_in), .ld_val(ld_val), .mem_rdata(mem_rdata), .addr_bus(addr_bus),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_wdata(ram_wdata),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .x_wr(x_wr), .x_wdata(x_wdata), .skip(skip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1: return "R5";  2: return "R6";  3: return "R7";  4: return "R8";
      5: return "R9";  6: return "R10"; 7: return "R11"; 8, 9: return "R2";
      10: return "R3";
      default: return "R12";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Called at a falling edge: drive, check same-cycle outputs, advance model,
  // then check registered outputs at the next falling edge.
  task automatic step(input int op, input int imm, input int a, input int x,
                      input int ld, input int rd);
    logic [3:0] lo, mid, nlo;
    bit mem, sw;
    op_code = 4'(op); op_imm = 3'(imm); acc_in = 4'(a); x_in = 4'(x);
    ld_val = 12'(ld); mem_rdata = 4'(rd);
    #1;
    mem = (op >= 1 && op <= 3);
    sw  = (op == 2 || op == 3);
    chk((m_mask != 0) ? "R4" : "R3", ram_addr, m_ptr & ~m_mask);
    chk("R5", ram_rd, mem);
    chk("R6", ram_wr, sw);
    if (sw) chk("R6", ram_wdata, a);
    lo = m_ptr[3:0]; mid = m_ptr[7:4];
    e_skip = 0; e_accwr = 0; e_xwr = 0;
    case (op)
      1, 2, 3: begin
        e_accwr = 1; e_acc = 4'(rd);
        m_ptr[6:4] = m_ptr[6:4] ^ ~3'(imm);
        m_mask = '0;
        if (op == 3) begin
          nlo = lo - 4'd1; m_ptr[3:0] = nlo; e_skip = (nlo == 4'hF);
        end
      end
      4: begin nlo = lo + 4'd1; m_ptr[3:0] = nlo; e_skip = (nlo == 4'h0); end
      5: begin nlo = lo - 4'd1; m_ptr[3:0] = nlo; e_skip = (nlo == 4'hF); end
      6: begin e_accwr = 1; e_acc = lo; m_ptr[3:0] = 4'(a); end
      7: begin e_xwr = 1; e_x = mid; m_ptr[7:4] = 4'(x); end
      8: m_ptr = 12'(ld);
      9: m_ptr[3:0] = 4'(ld);
      10: m_mask = 12'(ld);
      default: ;
    endcase
    @(negedge clk);
    chk(tag_of(op), addr_bus, m_ptr);
    chk("R12", skip, e_skip);
    chk(tag_of(op), acc_wr, e_accwr);
    if (e_accwr) chk(tag_of(op), acc_wdata, e_acc);
    chk("R11", x_wr, e_xwr);
    if (e_xwr) chk("R11", x_wdata, e_x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", addr_bus, 0); chk("R1", skip, 0); chk("R1", acc_wr, 0);
    chk("R1", x_wr, 0); chk("R1", ram_addr, 0);
    rst = 1'b0;
    // directed
    step(8, 0, 0, 0, 12'h12F, 0);  // R2 load all
    step(4, 0, 0, 0, 0, 0);        // R8 wrap F->0
    step(5, 0, 0, 0, 0, 0);        // R9 wrap 0->F
    step(5, 0, 0, 0, 0, 0);        // R9 no wrap
    step(1, 0, 3, 0, 0, 4'hA);     // R5 flip 6:4 by 7
    step(10, 0, 0, 0, 12'h0F0, 0); // R3 arm mask
    step(4, 0, 0, 0, 0, 0);        // R4 mask kept
    step(2, 7, 4'h6, 0, 0, 4'h5);  // R6 masked swap, no flip
    step(1, 2, 0, 0, 0, 4'h3);     // R4 mask gone
    step(9, 0, 0, 0, 12'hFF0, 0);  // R2 low only
    step(3, 5, 4'h9, 0, 0, 4'hC);  // R7 wrap to F
    step(3, 5, 4'h9, 0, 0, 4'h1);  // R7 no wrap
    step(6, 0, 4'h5, 0, 0, 0);     // R10
    step(7, 0, 0, 4'h9, 0, 0);     // R11
    step(13, 0, 0, 0, 12'hABC, 0); // R12 idle code
    step(0, 0, 0, 0, 12'h555, 0);  // R12 idle
    for (int i = 0; i < 600; i++)
      step(int'($urandom % 16), int'($urandom % 8), int'($urandom % 16),
           int'($urandom % 16), int'($urandom % 4096), int'($urandom % 16));
    finish_run();
  end
endmodule